// File: doc/BRIEF.md
# LPC I/O Write Target

This block is the bus-facing front end of a Low Pin Count peripheral that accepts host I/O write cycles. It watches the 4-bit multiplexed bus together with the active-low frame qualifier. It recognises a start nibble and checks the cycle-type nibble for an I/O write. It then collects a 16-bit port address and one data byte, and lets the host hand the bus over through a two-clock turnaround. The target then answers with synchronisation nibbles: a fixed run of long-wait codes, then the ready code. Last, it returns the bus through its own two-clock turnaround.

When the ready code goes out, the block pulses a one-clock write strobe with the captured address and byte. This happens only when the address lies inside a configurable, power-of-two-sized port window. All other cycle types are ignored until the next start. The bus reset clears the logic. A separate power-down input holds the front end idle for as long as it is low, and the block resumes normal decoding when it rises again, with no bus reset needed.

Top module: `lpcw_target`

## Requirements
- R1: While `rst_n` is low, or on every clock after `pwrdn_n` is sampled low, `nib_oe` is 0 and `wr_stb` is 0, and no cycle in progress at that time completes.
- R2: A cycle begins only on a clock where `frame_n` is 0 and `nib_in` is 4'b0000. A frame-low clock carrying any other nibble starts nothing.
- R3: The nibble after the start is accepted only when bits [3:1] are 3'b001 (I/O cycle, write direction; bit 0 is don't-care). Any other value makes the block ignore the bus, with no drive and no strobe, until the next start.
- R4: The address arrives as four nibbles, most significant first. The data byte arrives as two nibbles, low nibble first. The strobe presents exactly these values on `wr_addr` and `wr_data`.
- R5: During the start, type, address and data nibbles, and during the two turnaround clocks that follow the data, `nib_oe` stays 0.
- R6: Starting on the clock after the second turnaround clock, the target drives 4'b0110 (long wait) for exactly WAIT_CNT clocks (default 2), then 4'b0000 (ready) for one clock.
- R7: After the ready nibble, the target drives 4'b1111 for one clock, then sets `nib_oe` to 0 and returns to idle.
- R8: `wr_stb` is high for exactly one clock: the clock in which the ready nibble is driven. It rises only when `BASE_ADDR <= wr_addr < BASE_ADDR + WIN_SIZE` (default 0x0060 to 0x006F). Out-of-window writes still complete the sync handshake without a strobe.
- R9: A clock with `frame_n` low, in any state, aborts the current cycle. On the following clock `nib_oe` is 0, and the block decodes that clock's nibble as a possible start.
- R10: `pwrdn_n` may fall and rise again with `rst_n` held high throughout. After it rises, the next valid write cycle completes normally, including its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| pwrdn_n | input | 1 | Active-low power-down; holds the front end idle while low |
| frame_n | input | 1 | Active-low cycle framing qualifier |
| nib_in | input | 4 | Nibble sampled from the shared bus |
| nib_out | output | 4 | Nibble driven onto the shared bus by the target |
| nib_oe | output | 1 | Output enable for `nib_out`; 0 means released |
| wr_stb | output | 1 | One-clock write strobe to local registers |
| wr_addr | output | 16 | Captured I/O address |
| wr_data | output | 8 | Captured write byte |

## Verification
The assertions assume a well-behaved host, which has three parts. Once the target starts driving, the host keeps `frame_n` high until the target hands the bus back, except when it deliberately aborts. Power-down and reset change only between clock edges. The frame input is never unknown after reset.

The bench drives every input on the falling clock edge and holds frame high throughout the turnaround and sync phases. It pulls frame low only in the two deliberate abort scenarios, so the wait-count and turnaround properties see complete handshakes.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTYPE,
      ST_ADDR,
      ST_DATA,
      ST_TAR_H1,
      ST_TAR_H2,
      ST_SYNC_WAIT,
      ST_SYNC_DONE,
      ST_TAR_T1,
      ST_TAR_T2
   } lpcw_state_e;

   localparam logic [3:0] NIB_START     = 4'b0000;
   localparam logic [3:0] NIB_WAIT_LONG = 4'b0110;
   localparam logic [3:0] NIB_READY     = 4'b0000;
   localparam logic [3:0] NIB_ONES      = 4'b1111;

   // I/O cycle, write direction: bits [3:2]=00, bit 1=1, bit 0 don't-care
   function automatic logic is_io_write(input logic [3:0] n);
      return n[3:1] == 3'b001;
   endfunction

endpackage

// File: rtl/lpcw_seq.sv
module lpcw_seq
   import lpcw_pkg::*;
#(
   parameter int ADDR_NIBS = 4,
   parameter int WAIT_CNT  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pwrdn_n,
   input  logic        frame_n,
   input  logic [3:0]  nib_in,
   output lpcw_state_e st
);

   localparam int CNT_MAX = (ADDR_NIBS > WAIT_CNT) ? ADDR_NIBS : WAIT_CNT;
   localparam int CNT_W   = $clog2(CNT_MAX + 2);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
   localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CNT - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (!pwrdn_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (!frame_n) begin
         st  <= (nib_in == NIB_START) ? ST_CTYPE : ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_CTYPE: begin
               st  <= is_io_write(nib_in) ? ST_ADDR : ST_IDLE;
               cnt <= '0;
            end
            ST_ADDR: begin
               if (cnt == ADDR_LAST) begin
                  st  <= ST_DATA;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == DATA_LAST) begin
                  st  <= ST_TAR_H1;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_TAR_H1: st <= ST_TAR_H2;
            ST_TAR_H2: begin
               st  <= ST_SYNC_WAIT;
               cnt <= '0;
            end
            ST_SYNC_WAIT: begin
               if (cnt == WAIT_LAST) begin
                  st  <= ST_SYNC_DONE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_SYNC_DONE: st <= ST_TAR_T1;
            ST_TAR_T1:    st <= ST_TAR_T2;
            ST_TAR_T2:    st <= ST_IDLE;
            default:      st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lpcw_capture.sv
module lpcw_capture
   import lpcw_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter bit LOW_NIB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lpcw_state_e       st,
   input  logic              frame_n,
   input  logic [3:0]        nib_in,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        data
);

   wire take = frame_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (take && st == ST_ADDR) begin
         addr <= {addr[ADDR_W-5:0], nib_in};
      end
   end

   generate
      if (LOW_NIB_FIRST) begin : g_low_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data <= '0;
            end else if (take && st == ST_DATA) begin
               data <= {nib_in, data[7:4]};
            end
         end
      end else begin : g_high_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data <= '0;
            end else if (take && st == ST_DATA) begin
               data <= {data[3:0], nib_in};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lpcw_window.sv
module lpcw_window #(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0060,
   parameter int              WIN_SIZE  = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WIN_SIZE - 1);
   localparam logic [ADDR_W-1:0] MASK = ~SPAN;

   assign hit = (addr & MASK) == BASE_ADDR;

endmodule

// File: rtl/lpcw_target.sv
module lpcw_target
   import lpcw_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                WAIT_CNT      = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR     = 16'h0060,
   parameter int                WIN_SIZE      = 16,
   parameter bit                LOW_NIB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn_n,
   input  logic              frame_n,
   input  logic [3:0]        nib_in,
   output logic [3:0]        nib_out,
   output logic              nib_oe,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);

   localparam int ADDR_NIBS = ADDR_W / 4;

   generate
      if (ADDR_W < 4 || (ADDR_W % 4) != 0) begin : g_bad_addr_w
         $error("lpcw_target: ADDR_W must be a positive multiple of 4");
      end
      if (WAIT_CNT < 1) begin : g_bad_wait
         $error("lpcw_target: WAIT_CNT must be at least 1");
      end
      if (WIN_SIZE < 1 || (WIN_SIZE & (WIN_SIZE - 1)) != 0) begin : g_bad_win
         $error("lpcw_target: WIN_SIZE must be a power of two");
      end
      if ((BASE_ADDR & ADDR_W'(WIN_SIZE - 1)) != '0) begin : g_bad_base
         $error("lpcw_target: BASE_ADDR must be aligned to WIN_SIZE");
      end
   endgenerate

   lpcw_state_e st;
   logic        hit;

   lpcw_seq #(
      .ADDR_NIBS (ADDR_NIBS),
      .WAIT_CNT  (WAIT_CNT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwrdn_n (pwrdn_n),
      .frame_n (frame_n),
      .nib_in  (nib_in),
      .st      (st)
   );

   lpcw_capture #(
      .ADDR_W        (ADDR_W),
      .LOW_NIB_FIRST (LOW_NIB_FIRST)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .frame_n (frame_n),
      .nib_in  (nib_in),
      .addr    (wr_addr),
      .data    (wr_data)
   );

   lpcw_window #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .WIN_SIZE  (WIN_SIZE)
   ) u_window (
      .addr (wr_addr),
      .hit  (hit)
   );

   always_comb begin
      nib_out = NIB_ONES;
      nib_oe  = 1'b0;
      wr_stb  = 1'b0;
      case (st)
         ST_SYNC_WAIT: begin
            nib_oe  = 1'b1;
            nib_out = NIB_WAIT_LONG;
         end
         ST_SYNC_DONE: begin
            nib_oe  = 1'b1;
            nib_out = NIB_READY;
            wr_stb  = hit;
         end
         ST_TAR_T1: begin
            nib_oe  = 1'b1;
            nib_out = NIB_ONES;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpcw_target_chk.sv
module lpcw_target_chk #(
   parameter int                ADDR_W    = 16,
   parameter int                WAIT_CNT  = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0060,
   parameter int                WIN_SIZE  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwrdn_n,
   input logic              frame_n,
   input logic [3:0]        nib_out,
   input logic              nib_oe,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr
);

   localparam logic [3:0] C_WAIT  = 4'b0110;
   localparam logic [3:0] C_READY = 4'b0000;
   localparam logic [3:0] C_ONES  = 4'b1111;
   localparam logic [ADDR_W-1:0] C_MASK = ~ADDR_W'(WIN_SIZE - 1);

   logic [7:0] wait_run;
   wire drv_wait  = nib_oe && nib_out == C_WAIT;
   wire drv_ready = nib_oe && nib_out == C_READY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wait_run <= '0;
      else if (drv_wait) wait_run <= wait_run + 8'd1;
      else               wait_run <= '0;
   end

   assert_pd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrdn_n |=> (!nib_oe && !wr_stb));

   assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> !nib_oe);

   assert_first_drive_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nib_oe) |-> nib_out == C_WAIT);

   assert_wait_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_ready |-> wait_run == 8'(WAIT_CNT));

   assert_ready_then_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_ready && frame_n && pwrdn_n) |=> (nib_oe && nib_out == C_ONES));

   assert_stb_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> drv_ready);

   assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   assert_stb_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_addr & C_MASK) == BASE_ADDR);

endmodule

bind lpcw_target lpcw_target_chk #(
   .ADDR_W    (ADDR_W),
   .WAIT_CNT  (WAIT_CNT),
   .BASE_ADDR (BASE_ADDR),
   .WIN_SIZE  (WIN_SIZE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pwrdn_n (pwrdn_n),
   .frame_n (frame_n),
   .nib_out (nib_out),
   .nib_oe  (nib_oe),
   .wr_stb  (wr_stb),
   .wr_addr (wr_addr)
);

// File: tb/lpcw_target_bench.sv
module lpcw_target_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pwrdn_n;
   logic        frame_n;
   logic [3:0]  nib_in;
   logic [3:0]  nib_out;
   logic        nib_oe;
   logic        wr_stb;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [15:0] a;
      logic [7:0]  d;
   } wr_item_t;

   wr_item_t exp_q[$];

   always #5 clk = ~clk;

   lpcw_target u_lpcw_target (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwrdn_n (pwrdn_n),
      .frame_n (frame_n),
      .nib_in  (nib_in),
      .nib_out (nib_out),
      .nib_oe  (nib_oe),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   task automatic expect_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit in_window(input logic [15:0] a);
      return a >= 16'h0060 && a < 16'h0070;
   endfunction

   // one host clock; optionally confirm the target is not driving (R5)
   task automatic step(input logic f, input logic [3:0] n, input bit quiet);
      @(negedge clk);
      if (quiet) expect_eq("R5 host phase oe", int'(nib_oe), 0);
      frame_n = f;
      nib_in  = n;
   endtask

   task automatic send_frame(input logic [3:0] st_nib, input logic [3:0] cyc,
                             input logic [15:0] a, input logic [7:0] d);
      step(1'b0, st_nib, 1'b0);
      step(1'b1, cyc, 1'b1);
      for (int i = 3; i >= 0; i--) step(1'b1, a[i*4 +: 4], 1'b1);
      step(1'b1, d[3:0], 1'b1);   // low nibble first (R4)
      step(1'b1, d[7:4], 1'b1);
      step(1'b1, 4'hF, 1'b1);     // turnaround (R5)
      step(1'b1, 4'hF, 1'b1);
   endtask

   task automatic watch(input bit oe, input logic [3:0] n, input string req);
      @(negedge clk);
      expect_eq({req, " oe"}, int'(nib_oe), int'(oe));
      if (oe) expect_eq({req, " nibble"}, int'(nib_out), int'(n));
      frame_n = 1'b1;
      nib_in  = 4'hF;
   endtask

   task automatic expect_response(input bit drive);
      if (drive) begin
         watch(1'b1, 4'h6, "R6 wait1");
         watch(1'b1, 4'h6, "R6 wait2");
         watch(1'b1, 4'h0, "R6 ready");
         watch(1'b1, 4'hF, "R7 ones");
         watch(1'b0, 4'h0, "R7 release");
      end else begin
         repeat (5) watch(1'b0, 4'h0, "R3 no drive");
      end
   endtask

   task automatic do_write(input logic [3:0] cyc, input logic [15:0] a, input logic [7:0] d);
      wr_item_t it;
      it.a = a;
      it.d = d;
      if (in_window(a)) exp_q.push_back(it);
      send_frame(4'h0, cyc, a, d);
      expect_response(1'b1);
   endtask

   // monitor: scoreboard pop on each strobe (R4, R8)
   always @(negedge clk) begin
      if (wr_stb === 1'b1) begin
         if (exp_q.size() == 0) begin
            expect_eq("R8 unexpected strobe", 1, 0);
         end else begin
            wr_item_t it;
            it = exp_q.pop_front();
            expect_eq("R4 strobe addr", int'(wr_addr), int'(it.a));
            expect_eq("R4 strobe data", int'(wr_data), int'(it.d));
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n   = 1'b0;
      pwrdn_n = 1'b1;
      frame_n = 1'b1;
      nib_in  = 4'hF;
      repeat (3) @(negedge clk);
      expect_eq("R1 reset oe", int'(nib_oe), 0);
      expect_eq("R1 reset stb", int'(wr_stb), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // basic writes, in and out of window, window edges (R4 R6 R7 R8)
      do_write(4'h2, 16'h0064, 8'hA5);
      do_write(4'h2, 16'h1234, 8'h3C);
      do_write(4'h2, 16'h0060, 8'hFE);
      do_write(4'h2, 16'h006F, 8'h01);
      do_write(4'h2, 16'h0070, 8'h99);
      do_write(4'h2, 16'h005F, 8'h42);
      do_write(4'h3, 16'h0062, 8'h0F);   // R3 bit 0 don't-care

      // R2: frame low with non-start nibble
      send_frame(4'h5, 4'h2, 16'h0061, 8'h11);
      expect_response(1'b0);

      // R3: read and memory cycle types ignored
      send_frame(4'h0, 4'h0, 16'h0061, 8'h22);
      expect_response(1'b0);
      send_frame(4'h0, 4'h4, 16'h0061, 8'h33);
      expect_response(1'b0);

      // R9: abort during address phase
      step(1'b0, 4'h0, 1'b0);
      step(1'b1, 4'h2, 1'b1);
      step(1'b1, 4'h0, 1'b1);
      step(1'b0, 4'hF, 1'b1);
      repeat (3) watch(1'b0, 4'h0, "R9 after abort");
      do_write(4'h2, 16'h0066, 8'hC3);

      // R9: abort while the target drives a wait nibble
      send_frame(4'h0, 4'h2, 16'h0061, 8'h77);
      @(negedge clk);
      expect_eq("R9 driving before abort", int'(nib_oe), 1);
      frame_n = 1'b0;
      nib_in  = 4'hF;
      @(negedge clk);
      expect_eq("R9 released after abort", int'(nib_oe), 0);
      frame_n = 1'b1;
      repeat (3) watch(1'b0, 4'h0, "R9 idle");

      // R1 / R10: power-down mid-cycle, full frame while down, then recover
      step(1'b0, 4'h0, 1'b0);
      step(1'b1, 4'h2, 1'b1);
      step(1'b1, 4'h0, 1'b1);
      @(negedge clk);
      pwrdn_n = 1'b0;
      send_frame(4'h0, 4'h2, 16'h0063, 8'h55);
      repeat (5) watch(1'b0, 4'h0, "R1 power-down quiet");
      @(negedge clk);
      pwrdn_n = 1'b1;
      do_write(4'h2, 16'h0065, 8'h5A);
      do_write(4'h2, 16'h0067, 8'hB4);

      repeat (3) @(negedge clk);
      expect_eq("R8 all strobes seen", exp_q.size(), 0);
      finish_run();
   end

endmodule